// File: doc/BRIEF.md
# Dual-Bank Micro-Operation Executor

This block carries out one micro-operation at a time against two register banks, low (encoding 0) and high (encoding 1). Each bank has 14 slots, and each slot holds one multi-word field element of 8 words of 32 bits. Word 0 is the least significant word. The slot index space is fixed:

| Index | Slot |
|-------|------|
| 0 | constant zero |
| 1 | constant one |
| 2 | scratch R1 |
| 3 | scratch R2 |
| 4 to 13 | temporaries |

There are five micro-operations. A single copy moves one slot, and a paired copy moves two slots. A load fills a slot from an external word memory, and a store empties a slot into that memory. An arithmetic step takes both of its operands from one bank and hands them to an external multi-word arithmetic unit. That unit sits behind a start/done handshake, and the block writes its result into a slot of either bank.

A caller presents a micro-operation with `uop_valid` while `busy` is low. The block then runs a small state machine:

- `ST_IDLE` accepts the micro-operation.
- `ST_COPY` moves the first slot, or runs the load or the store, one word per cycle.
- `ST_COPY2` moves the second slot of a paired copy.
- `ST_START` pulses `au_start`.
- `ST_WAIT` holds until `au_done`, capturing `au_result` on that edge.
- `ST_WB` writes the captured result one word per cycle.
- `ST_FINISH` raises `done` for one cycle and then returns to `ST_IDLE`.

These are the transitions:

- `ST_IDLE` goes to `ST_COPY` for the copy, load and store kinds, to `ST_START` for the arithmetic kind, and to `ST_FINISH` for any other kind.
- `ST_COPY` goes to `ST_COPY2` for a paired copy, and to `ST_FINISH` otherwise.
- `ST_COPY2` goes to `ST_FINISH`.
- `ST_START` goes to `ST_WAIT`.
- `ST_WAIT` goes to `ST_WB`.
- `ST_WB` goes to `ST_FINISH`.
- `ST_FINISH` goes to `ST_IDLE`.

Top module: `uop_exec`

## Requirements
- R1: After reset, `busy`, `done`, `au_start` and `mem_we` are low. Slot 0 of both banks reads as all zero, slot 1 reads as the value one (word 0 = 1, other words 0), and all other slots read as zero.
- R2: A single copy (`uop_kind`=0) copies all 8 words of slot `uop_src_a` in bank `uop_src_bank` to slot `uop_dst_a` in bank `uop_dst_bank` (bank code 0=low, 1=high). `done` is high in the 8th cycle after the accepting edge.
- R3: A paired copy (`uop_kind`=1) first copies `uop_src_a` to `uop_dst_a`, then copies `uop_src_b` to `uop_dst_b`, using the same bank pair for both. The second copy sees the result of the first. `done` comes 16 cycles after acceptance.
- R4: A load (`uop_kind`=2) writes `mem_rdata` at `mem_addr`=w into word w of slot `uop_dst_a` in bank `uop_dst_bank`, for w = 0..7. `done` comes 8 cycles after acceptance.
- R5: A store (`uop_kind`=3) asserts `mem_we` with word w of slot `uop_src_a` in bank `uop_src_bank` on `mem_wdata` at `mem_addr`=w, for w = 0..7. It writes no slot, and `done` comes 8 cycles after acceptance.
- R6: An arithmetic step (`uop_kind`=4) pulses `au_start` for exactly one cycle, one cycle after acceptance. It presents the following and holds them until `au_done`:
  - slots `uop_src_a` and `uop_src_b` of the single bank `uop_src_bank` on `au_opa` and `au_opb` (word w at bits 32w+31..32w);
  - `uop_math` on `au_math` (0 add, 1 subtract, 2 multiply);
  - `uop_mod` on `au_mod` (0 selects p, 1 selects 2p).
- R7: `au_result` sampled on the edge where `au_done` is high is written to slot `uop_dst_a` of bank `uop_dst_bank`. `done` follows 8 cycles after that edge.
- R8: Writes of any kind aimed at slot 0 or slot 1 leave those slots unchanged.
- R9: `busy` is high from the accepting edge until `done` and is low afterwards. `done` lasts one cycle. `uop_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop_valid | input | 1 | Micro-operation present |
| uop_kind | input | 3 | 0 copy, 1 paired copy, 2 load, 3 store, 4 arithmetic |
| uop_math | input | 2 | Arithmetic function code |
| uop_mod | input | 1 | Modulus select |
| uop_src_bank | input | 1 | Source bank |
| uop_src_a | input | 4 | First source slot |
| uop_src_b | input | 4 | Second source slot |
| uop_dst_bank | input | 1 | Destination bank |
| uop_dst_a | input | 4 | First destination slot |
| uop_dst_b | input | 4 | Second destination slot |
| busy | output | 1 | Micro-operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 3 | External memory word index |
| mem_rdata | input | 32 | External memory read data, same cycle |
| mem_we | output | 1 | External memory write enable |
| mem_wdata | output | 32 | External memory write data |
| au_start | output | 1 | Arithmetic unit start pulse |
| au_math | output | 2 | Arithmetic function for the unit |
| au_mod | output | 1 | Modulus select for the unit |
| au_opa | output | 256 | First operand, flat |
| au_opb | output | 256 | Second operand, flat |
| au_done | input | 1 | Arithmetic unit completion |
| au_result | input | 256 | Arithmetic unit result, valid with `au_done` |

## Verification
The assertions take three things for granted:

- `au_done` rises only in answer to an `au_start`, and does so at most once per step.
- Slot indices stay below 14.
- `uop_kind` stays within codes 0 to 4.

The stimulus keeps within these limits. The bench's arithmetic unit model replies to each start exactly once, after a random delay of 0 to 4 cycles. Every generated slot index is drawn from 0 to 13. Even the junk fields driven with `uop_valid` during `busy` use only legal kinds.

// File: rtl/uop_exec_pkg.sv
package uop_exec_pkg;

    typedef enum logic [2:0] {
        UK_MOVE  = 3'd0,
        UK_MOVE2 = 3'd1,
        UK_LOAD  = 3'd2,
        UK_STORE = 3'd3,
        UK_CALC  = 3'd4
    } uop_kind_e;

    typedef enum logic [1:0] {
        DS_BANK = 2'd0,
        DS_EXT  = 2'd1,
        DS_RES  = 2'd2
    } data_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_COPY   = 3'd1,
        ST_COPY2  = 3'd2,
        ST_START  = 3'd3,
        ST_WAIT   = 3'd4,
        ST_WB     = 3'd5,
        ST_FINISH = 3'd6
    } exec_state_e;

    localparam int unsigned BANK_COUNT     = 2;
    localparam int unsigned FIRST_WRITABLE = 2;

endpackage

// File: rtl/uop_bank.sv
module uop_bank
    import uop_exec_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned WORDS  = 8,
    parameter int unsigned SLOTS  = 14,
    parameter int unsigned SIDX_W = $clog2(SLOTS),
    parameter int unsigned WIDX_W = $clog2(WORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SIDX_W-1:0]         wr_slot,
    input  logic [WIDX_W-1:0]         wr_word,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic [SIDX_W-1:0]         rd_slot,
    input  logic [WIDX_W-1:0]         rd_word,
    output logic [WORD_W-1:0]         rd_data,
    input  logic [SIDX_W-1:0]         opa_slot,
    input  logic [SIDX_W-1:0]         opb_slot,
    output logic [WORDS*WORD_W-1:0]   opa_flat,
    output logic [WORDS*WORD_W-1:0]   opb_flat
);

    logic [WORD_W-1:0] mem [SLOTS][WORDS];
    logic              wr_allowed;

    // constant slots never take a write
    assign wr_allowed = wr_en && (32'(wr_slot) >= FIRST_WRITABLE) && (32'(wr_slot) < SLOTS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) begin
                for (int w = 0; w < WORDS; w++) begin
                    mem[s][w] <= (s == 1 && w == 0) ? WORD_W'(1) : '0;
                end
            end
        end else if (wr_allowed) begin
            mem[wr_slot][wr_word] <= wr_data;
        end
    end

    assign rd_data = mem[rd_slot][rd_word];

    for (genvar w = 0; w < WORDS; w++) begin : g_flat
        assign opa_flat[w*WORD_W +: WORD_W] = mem[opa_slot][w];
        assign opb_flat[w*WORD_W +: WORD_W] = mem[opb_slot][w];
    end

    // R8: constant slots keep their values whatever is written
    p_const_slots_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem[0][0] == '0) && (mem[1][0] == WORD_W'(1)) && (mem[1][WORDS-1] == '0));

    // R8: a write aimed at a constant slot is dropped
    p_const_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot == SIDX_W'(1)) |=> $stable(mem[1][0]));

endmodule

// File: rtl/uop_ctrl.sv
module uop_ctrl
    import uop_exec_pkg::*;
#(
    parameter int unsigned WORDS  = 8,
    parameter int unsigned SIDX_W = 4,
    parameter int unsigned WIDX_W = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               uop_valid,
    input  logic [2:0]         uop_kind,
    input  logic [1:0]         uop_math,
    input  logic               uop_mod,
    input  logic               uop_src_bank,
    input  logic [SIDX_W-1:0]  uop_src_a,
    input  logic [SIDX_W-1:0]  uop_src_b,
    input  logic               uop_dst_bank,
    input  logic [SIDX_W-1:0]  uop_dst_a,
    input  logic [SIDX_W-1:0]  uop_dst_b,
    input  logic               au_done,
    output logic               busy,
    output logic               done,
    output logic               au_start,
    output logic [1:0]         au_math,
    output logic               au_mod,
    output logic [WIDX_W-1:0]  word,
    output logic               rd_bank,
    output logic [SIDX_W-1:0]  rd_slot,
    output logic               wr_en,
    output logic               wr_bank,
    output logic [SIDX_W-1:0]  wr_slot,
    output data_sel_e          data_sel,
    output logic               mem_we,
    output logic               res_capture,
    output logic               op_bank,
    output logic [SIDX_W-1:0]  opa_slot,
    output logic [SIDX_W-1:0]  opb_slot
);

    localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(WORDS - 1);

    exec_state_e       state_q, state_d;
    uop_kind_e         kind_q;
    logic [1:0]        math_q;
    logic              mod_q;
    logic              sbank_q, dbank_q;
    logic [SIDX_W-1:0] sa_q, sb_q, da_q, db_q;
    logic [WIDX_W-1:0] word_q;
    logic              accept;
    logic              last_word;
    logic              counting;

    assign accept    = (state_q == ST_IDLE) && uop_valid;
    assign last_word = (word_q == LAST_WORD);
    assign counting  = (state_q == ST_COPY) || (state_q == ST_COPY2) || (state_q == ST_WB);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (uop_valid) begin
                    unique case (uop_kind)
                        3'd0, 3'd1, 3'd2, 3'd3: state_d = ST_COPY;
                        3'd4:                   state_d = ST_START;
                        default:                state_d = ST_FINISH;
                    endcase
                end
            end
            ST_COPY: begin
                if (last_word) state_d = (kind_q == UK_MOVE2) ? ST_COPY2 : ST_FINISH;
            end
            ST_COPY2: begin
                if (last_word) state_d = ST_FINISH;
            end
            ST_START:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (au_done) state_d = ST_WB;
            end
            ST_WB: begin
                if (last_word) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register with latched micro-operation fields and word counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= UK_MOVE;
            math_q  <= '0;
            mod_q   <= 1'b0;
            sbank_q <= 1'b0;
            dbank_q <= 1'b0;
            sa_q    <= '0;
            sb_q    <= '0;
            da_q    <= '0;
            db_q    <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q  <= uop_kind_e'(uop_kind);
                math_q  <= uop_math;
                mod_q   <= uop_mod;
                sbank_q <= uop_src_bank;
                dbank_q <= uop_dst_bank;
                sa_q    <= uop_src_a;
                sb_q    <= uop_src_b;
                da_q    <= uop_dst_a;
                db_q    <= uop_dst_b;
                word_q  <= '0;
            end else if (counting) begin
                word_q  <= last_word ? '0 : word_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        done        = 1'b0;
        au_start    = 1'b0;
        wr_en       = 1'b0;
        mem_we      = 1'b0;
        res_capture = 1'b0;
        data_sel    = DS_BANK;
        rd_bank     = sbank_q;
        rd_slot     = sa_q;
        wr_bank     = dbank_q;
        wr_slot     = da_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_COPY: begin
                unique case (kind_q)
                    UK_STORE: mem_we = 1'b1;
                    UK_LOAD: begin
                        data_sel = DS_EXT;
                        wr_en    = 1'b1;
                    end
                    default:  wr_en = 1'b1;
                endcase
            end
            ST_COPY2: begin
                rd_slot = sb_q;
                wr_slot = db_q;
                wr_en   = 1'b1;
            end
            ST_START:  au_start = 1'b1;
            ST_WAIT:   res_capture = au_done;
            ST_WB: begin
                data_sel = DS_RES;
                wr_en    = 1'b1;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign word     = word_q;
    assign au_math  = math_q;
    assign au_mod   = mod_q;
    assign op_bank  = sbank_q;
    assign opa_slot = sa_q;
    assign opb_slot = sb_q;

    // R6: start is a single-cycle pulse
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        au_start |=> !au_start);

    // R6: the step waits for the unit and never restarts it while waiting
    p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !au_done) |=> (state_q == ST_WAIT && !au_start && !wr_en));

    // R9: done lasts one cycle and the block is idle right after
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: busy falls only after a done cycle
    p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R5: a store never writes a slot
    p_store_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!wr_en && busy));

endmodule

// File: rtl/uop_exec.sv
module uop_exec
    import uop_exec_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned WORDS  = 8,
    parameter int unsigned SLOTS  = 14,
    parameter int unsigned SIDX_W = $clog2(SLOTS),
    parameter int unsigned WIDX_W = $clog2(WORDS),
    parameter int unsigned FLAT_W = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uop_valid,
    input  logic [2:0]        uop_kind,
    input  logic [1:0]        uop_math,
    input  logic              uop_mod,
    input  logic              uop_src_bank,
    input  logic [SIDX_W-1:0] uop_src_a,
    input  logic [SIDX_W-1:0] uop_src_b,
    input  logic              uop_dst_bank,
    input  logic [SIDX_W-1:0] uop_dst_a,
    input  logic [SIDX_W-1:0] uop_dst_b,
    output logic              busy,
    output logic              done,
    output logic [WIDX_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              au_start,
    output logic [1:0]        au_math,
    output logic              au_mod,
    output logic [FLAT_W-1:0] au_opa,
    output logic [FLAT_W-1:0] au_opb,
    input  logic              au_done,
    input  logic [FLAT_W-1:0] au_result
);

    logic [WIDX_W-1:0] word;
    logic              rd_bank, wr_bank, wr_en, op_bank, res_capture;
    logic [SIDX_W-1:0] rd_slot, wr_slot, opa_slot, opb_slot;
    data_sel_e         data_sel;
    logic [WORD_W-1:0] wr_data;
    logic [FLAT_W-1:0] res_q;

    logic [WORD_W-1:0] bank_rd  [BANK_COUNT];
    logic [FLAT_W-1:0] bank_opa [BANK_COUNT];
    logic [FLAT_W-1:0] bank_opb [BANK_COUNT];

    uop_ctrl #(
        .WORDS  (WORDS),
        .SIDX_W (SIDX_W),
        .WIDX_W (WIDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .uop_valid    (uop_valid),
        .uop_kind     (uop_kind),
        .uop_math     (uop_math),
        .uop_mod      (uop_mod),
        .uop_src_bank (uop_src_bank),
        .uop_src_a    (uop_src_a),
        .uop_src_b    (uop_src_b),
        .uop_dst_bank (uop_dst_bank),
        .uop_dst_a    (uop_dst_a),
        .uop_dst_b    (uop_dst_b),
        .au_done      (au_done),
        .busy         (busy),
        .done         (done),
        .au_start     (au_start),
        .au_math      (au_math),
        .au_mod       (au_mod),
        .word         (word),
        .rd_bank      (rd_bank),
        .rd_slot      (rd_slot),
        .wr_en        (wr_en),
        .wr_bank      (wr_bank),
        .wr_slot      (wr_slot),
        .data_sel     (data_sel),
        .mem_we       (mem_we),
        .res_capture  (res_capture),
        .op_bank      (op_bank),
        .opa_slot     (opa_slot),
        .opb_slot     (opb_slot)
    );

    for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
        uop_bank #(
            .WORD_W (WORD_W),
            .WORDS  (WORDS),
            .SLOTS  (SLOTS),
            .SIDX_W (SIDX_W),
            .WIDX_W (WIDX_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_bank == 1'(b))),
            .wr_slot  (wr_slot),
            .wr_word  (word),
            .wr_data  (wr_data),
            .rd_slot  (rd_slot),
            .rd_word  (word),
            .rd_data  (bank_rd[b]),
            .opa_slot (opa_slot),
            .opb_slot (opb_slot),
            .opa_flat (bank_opa[b]),
            .opb_flat (bank_opb[b])
        );
    end

    // result holding register, filled on the unit's done
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           res_q <= '0;
        else if (res_capture) res_q <= au_result;
    end

    always_comb begin
        unique case (data_sel)
            DS_EXT:  wr_data = mem_rdata;
            DS_RES:  wr_data = res_q[word*WORD_W +: WORD_W];
            default: wr_data = bank_rd[rd_bank];
        endcase
    end

    assign mem_addr  = word;
    assign mem_wdata = bank_rd[rd_bank];
    assign au_opa    = bank_opa[op_bank];
    assign au_opb    = bank_opb[op_bank];

    // R6: operands stay put while the unit works
    p_operands_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (au_start || (busy && $past(au_start))) |=> $stable(au_opa) && $stable(au_opb));

    // R4: a load writes memory data into the bank, never the memory
    p_load_no_memwrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_sel == DS_EXT && wr_en) |-> !mem_we);

endmodule

// File: tb/test_uop_exec.sv
`timescale 1ns/1ps
module test_uop_exec;

    localparam int WORD_W = 32;
    localparam int WORDS  = 8;
    localparam int SLOTS  = 14;
    localparam int FLAT_W = WORD_W * WORDS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              uop_valid = 1'b0;
    logic [2:0]        uop_kind = '0;
    logic [1:0]        uop_math = '0;
    logic              uop_mod = 1'b0;
    logic              uop_src_bank = 1'b0;
    logic [3:0]        uop_src_a = '0, uop_src_b = '0;
    logic              uop_dst_bank = 1'b0;
    logic [3:0]        uop_dst_a = '0, uop_dst_b = '0;
    logic              busy, done;
    logic [2:0]        mem_addr;
    logic [31:0]       mem_rdata;
    logic              mem_we;
    logic [31:0]       mem_wdata;
    logic              au_start;
    logic [1:0]        au_math;
    logic              au_mod;
    logic [FLAT_W-1:0] au_opa, au_opb;
    logic              au_done = 1'b0;
    logic [FLAT_W-1:0] au_result = '0;

    uop_exec i_uop_exec (
        .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop_kind(uop_kind),
        .uop_math(uop_math), .uop_mod(uop_mod), .uop_src_bank(uop_src_bank),
        .uop_src_a(uop_src_a), .uop_src_b(uop_src_b), .uop_dst_bank(uop_dst_bank),
        .uop_dst_a(uop_dst_a), .uop_dst_b(uop_dst_b), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .au_start(au_start), .au_math(au_math),
        .au_mod(au_mod), .au_opa(au_opa), .au_opb(au_opb), .au_done(au_done),
        .au_result(au_result)
    );

    always #2.5 clk = ~clk;

    logic [31:0]       mdl [2][SLOTS][WORDS];
    logic [31:0]       xmem [WORDS];
    logic [31:0]       stored [WORDS];
    int                vectors = 0;
    int                miscompares = 0;
    int                au_starts = 0;
    int                au_pending = 0;
    int                au_delay = 0;
    int                cur_delay = 0;
    int                exp_sbank = 0, exp_sa = 0, exp_sb = 0, exp_math = 0, exp_mod = 0;
    logic [FLAT_W-1:0] au_hold = '0;
    bit                finished = 0;

    assign mem_rdata = xmem[mem_addr];

    function automatic logic [FLAT_W-1:0] mflat(int b, int s);
        logic [FLAT_W-1:0] r;
        for (int w = 0; w < WORDS; w++) r[w*WORD_W +: WORD_W] = mdl[b][s][w];
        return r;
    endfunction

    function automatic logic [FLAT_W-1:0] au_fn(logic [FLAT_W-1:0] a, logic [FLAT_W-1:0] b,
                                                int m, int md);
        logic [FLAT_W-1:0] r;
        for (int w = 0; w < WORDS; w++)
            r[w*WORD_W +: WORD_W] = a[w*WORD_W +: WORD_W] + b[w*WORD_W +: WORD_W] * (m + 1) + 32'(md);
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [FLAT_W-1:0] act, logic [FLAT_W-1:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // external memory write capture
    always @(negedge clk) if (mem_we) stored[mem_addr] = mem_wdata;

    // arithmetic unit model
    always @(negedge clk) begin
        au_done = 1'b0;
        if (au_pending != 0) begin
            if (au_delay == 0) begin
                au_done    = 1'b1;
                au_result  = au_hold;
                au_pending = 0;
            end else begin
                au_delay--;
            end
        end
        if (au_start) begin
            au_starts++;
            chk(au_opa == mflat(exp_sbank, exp_sa), "R6", "operand a", au_opa, mflat(exp_sbank, exp_sa));
            chk(au_opb == mflat(exp_sbank, exp_sb), "R6", "operand b", au_opb, mflat(exp_sbank, exp_sb));
            chk(au_math == 2'(exp_math) && au_mod == 1'(exp_mod), "R6", "math/mod",
                {au_math, au_mod}, {2'(exp_math), 1'(exp_mod)});
            au_hold    = au_fn(au_opa, au_opb, au_math, au_mod);
            au_pending = 1;
            au_delay   = cur_delay;
        end
    end

    task automatic junk_fields();
        uop_kind     = 3'($urandom_range(0, 4));
        uop_math     = 2'($urandom_range(0, 2));
        uop_mod      = 1'($urandom);
        uop_src_bank = 1'($urandom);
        uop_dst_bank = 1'($urandom);
        uop_src_a    = 4'($urandom_range(0, 13));
        uop_src_b    = 4'($urandom_range(0, 13));
        uop_dst_a    = 4'($urandom_range(0, 13));
        uop_dst_b    = 4'($urandom_range(0, 13));
    endtask

    task automatic run_op(int kind, int sbk, int sa, int sb, int dbk, int da, int db, int m, int md);
        int  n;
        bit  busy_ok;
        int  exp_n;
        int  starts0;
        logic [FLAT_W-1:0] tmp;
        exp_sbank = sbk; exp_sa = sa; exp_sb = sb; exp_math = m; exp_mod = md;
        cur_delay = $urandom_range(0, 4);
        if (kind == 2) for (int w = 0; w < WORDS; w++) xmem[w] = $urandom;
        for (int w = 0; w < WORDS; w++) stored[w] = 32'hdead_0000 + 32'(w);
        starts0 = au_starts;
        @(negedge clk);
        uop_kind = 3'(kind); uop_math = 2'(m); uop_mod = 1'(md);
        uop_src_bank = 1'(sbk); uop_src_a = 4'(sa); uop_src_b = 4'(sb);
        uop_dst_bank = 1'(dbk); uop_dst_a = 4'(da); uop_dst_b = 4'(db);
        uop_valid = 1'b1;
        @(posedge clk);
        n = 0;
        busy_ok = 1;
        forever begin
            @(negedge clk);
            if (done) begin
                uop_valid = 1'b0;
                break;
            end
            if (!busy) busy_ok = 0;
            junk_fields();   // R9: must be ignored while busy
            if (n > 300) begin
                uop_valid = 1'b0;
                break;
            end
            @(posedge clk);
            n++;
        end
        chk(busy_ok, "R9", "busy during op", FLAT_W'(busy_ok), FLAT_W'(1));
        case (kind)
            0: exp_n = 8;
            1: exp_n = 16;
            2: exp_n = 8;
            3: exp_n = 8;
            default: exp_n = 10 + cur_delay;
        endcase
        chk(n == exp_n, kind == 1 ? "R3" : (kind == 4 ? "R7" : "R2"), "done latency",
            FLAT_W'(n), FLAT_W'(exp_n));
        case (kind)
            0: if (da >= 2) for (int w = 0; w < WORDS; w++) mdl[dbk][da][w] = mdl[sbk][sa][w];
            1: begin
                if (da >= 2) for (int w = 0; w < WORDS; w++) mdl[dbk][da][w] = mdl[sbk][sa][w];
                if (db >= 2) for (int w = 0; w < WORDS; w++) mdl[dbk][db][w] = mdl[sbk][sb][w];
            end
            2: if (da >= 2) for (int w = 0; w < WORDS; w++) mdl[dbk][da][w] = xmem[w];
            3: begin
                for (int w = 0; w < WORDS; w++) tmp[w*WORD_W +: WORD_W] = stored[w];
                chk(tmp == mflat(sbk, sa), "R5", $sformatf("store bank %0d slot %0d", sbk, sa),
                    tmp, mflat(sbk, sa));
            end
            default: begin
                chk(au_starts == starts0 + 1, "R6", "one start per step",
                    FLAT_W'(au_starts - starts0), FLAT_W'(1));
                tmp = au_fn(mflat(sbk, sa), mflat(sbk, sb), m, md);
                if (da >= 2) for (int w = 0; w < WORDS; w++) mdl[dbk][da][w] = tmp[w*WORD_W +: WORD_W];
            end
        endcase
        @(negedge clk);
        chk(!busy && !done, "R9", "idle after done", FLAT_W'({busy, done}), '0);
    endtask

    task automatic dump_all();
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < SLOTS; s++) run_op(3, b, s, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual hung expected completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'd24680));
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < SLOTS; s++)
                for (int w = 0; w < WORDS; w++)
                    mdl[b][s][w] = (s == 1 && w == 0) ? 32'd1 : 32'd0;
        for (int w = 0; w < WORDS; w++) xmem[w] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs low in and right after reset
        chk(!busy && !done && !au_start && !mem_we, "R1", "reset outputs",
            FLAT_W'({busy, done, au_start, mem_we}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !au_start && !mem_we, "R1", "post-reset outputs",
            FLAT_W'({busy, done, au_start, mem_we}), '0);
        dump_all();   // R1: constant and cleared slots

        // directed: fill some slots, R4 load
        run_op(2, 0, 0, 0, 0, 2, 0, 0, 0);
        run_op(2, 0, 0, 0, 1, 5, 0, 0, 0);
        run_op(2, 0, 0, 0, 0, 4, 0, 0, 0);
        // R2 cross-bank copy
        run_op(0, 1, 5, 0, 0, 6, 0, 0, 0);
        // R3 chained paired copy: second copy reads slot written by the first
        run_op(1, 0, 2, 3, 0, 3, 7, 0, 0);
        // R8 writes toward constant slots
        run_op(0, 0, 2, 0, 0, 0, 0, 0, 0);
        run_op(2, 0, 0, 0, 1, 1, 0, 0, 0);
        run_op(4, 0, 4, 4, 1, 1, 0, 2, 1);
        run_op(1, 1, 5, 5, 1, 0, 1, 0, 0);
        // R6/R7 arithmetic with the same slot twice and across banks
        run_op(4, 0, 4, 4, 1, 9, 0, 2, 1);
        run_op(4, 1, 5, 9, 0, 13, 0, 1, 0);
        run_op(4, 0, 0, 1, 0, 12, 0, 0, 0);
        dump_all();

        // constrained random mix
        for (int i = 0; i < 250; i++) begin
            int k;
            k = $urandom_range(0, 4);
            run_op(k, $urandom_range(0, 1), $urandom_range(0, 13), $urandom_range(0, 13),
                   $urandom_range(0, 1), $urandom_range(0, 13), $urandom_range(0, 13),
                   $urandom_range(0, 2), $urandom_range(0, 1));
        end
        dump_all();   // R8: constants survived everything
        finished = 1;
        report();
    end

endmodule